// File: doc/BRIEF.md
# Clock Request Gating Controller

This block decides, every cycle, which of four system clocks keeps running. The four domains are the main processor clock, the sub-main peripheral clock, the auxiliary clock and the internal module oscillator. A sleep input and a three-bit sleep level choose which domains the power mode would stop. Each domain also has a bundle of peripheral request lines. An enabled request overrides the sleep level and keeps its clock running. A per-domain override-enable register chooses whether a domain honours requests at all.

Each domain has a small state machine with three states:
- `DS_RUN`: running because the power mode allows it.
- `DS_HELD`: running only because an enabled request overrides the mode.
- `DS_OFF`: stopped.

The transitions are named as follows:
- `T_STOP`: RUN to OFF.
- `T_HOLD`: RUN to HELD.
- `T_WAKE`: OFF to RUN.
- `T_REQ_ON`: OFF to HELD.
- `T_RELEASE`: HELD to RUN.
- `T_REQ_OFF`: HELD to OFF.

State registers update on the falling edge of the reference clock. A downstream AND-type gate therefore sees each enable change only while the clock is low, so the gated clocks carry no glitches. A per-domain held flag and a combined flag show that some module is keeping a clock alive that the chosen power mode should have stopped. Software can use the combined flag to find excess power draw.

Top module: `clk_req_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `clk_en` reads 4'b1111, `ovr_hold` reads 0, `ovr_any` reads 0 and `reqen_q` reads 4'b1111.
- R2: With `sleep` low, all four domains run and no held bit is set, whatever the requests are.
- R3: With `sleep` high and no enabled request, the stopped set depends on `lpm_lvl` as follows:
  - Level 0 stops only the main clock (bit 0).
  - Levels 1 to 3 stop the main and sub-main clocks (bits 0 and 1).
  - Levels 4 to 7 stop all four domains.
  - The auxiliary clock is bit 2 and the module oscillator is bit 3.
- R4: Domain k takes its requests from `periph_req[k*N_REQ +: N_REQ]`. If any one of those lines is high and `reqen_q[k]` is 1, a domain that the level would stop keeps running, and `ovr_hold[k]` is 1.
- R5: When `reqen_q[k]` is 0, requests for domain k have no effect, and the level alone decides `clk_en[k]`.
- R6: `ovr_hold[k]` is 1 only when the level would stop domain k. A request for a domain the mode leaves running does not set its held bit.
- R7: `ovr_any` is 1 exactly when at least one `ovr_hold` bit is 1.
- R8: `clk_en`, `ovr_hold` and `ovr_any` change only at a falling edge of `clk`. They reflect the inputs and `reqen_q` sampled at that edge, and they stay stable across the following rising edge.
- R9: A rising edge with `reqen_wr` high loads `reqen_wdata` into `reqen_q`. The new value first governs decisions at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Low-power mode active |
| lpm_lvl | input | 3 | Sleep level (0..4; 5..7 act as 4) |
| periph_req | input | 4*N_REQ | Request lines, domain k at bits k*N_REQ +: N_REQ |
| reqen_wr | input | 1 | Write strobe for override-enable register |
| reqen_wdata | input | 4 | Override-enable write value, bit k = domain k |
| reqen_q | output | 4 | Override-enable register contents |
| clk_en | output | 4 | Clock enable per domain, falling-edge registered |
| ovr_hold | output | 4 | Domain running only because of a request |
| ovr_any | output | 1 | Any domain held by a request |

## Verification
The bench builds the block with the default of eight request lines per domain. It walks a single high line through every position of every domain, which shows that no line in a bundle is dropped. It sweeps all eight sleep-level codes, so the three aliased top codes are covered, and it clears each override-enable bit in turn. A long random phase mixes register writes with level changes, which exercises all six transitions of the per-domain state machine.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    localparam int N_CLK   = 4;
    localparam int CK_MAIN = 0;
    localparam int CK_SUB  = 1;
    localparam int CK_AUX  = 2;
    localparam int CK_MOD  = 3;

    typedef enum logic [1:0] {
        DS_OFF  = 2'b00,
        DS_RUN  = 2'b01,
        DS_HELD = 2'b11
    } dom_state_t;
endpackage

// File: rtl/cg_lpm_decode.sv
module cg_lpm_decode
    import clkgate_pkg::*;
(
    input  logic             sleep,
    input  logic [2:0]       lpm_lvl,
    output logic [N_CLK-1:0] stop_mask
);
    always_comb begin
        stop_mask = '0;
        if (sleep) begin
            unique case (lpm_lvl)
                3'd0:                stop_mask = 4'b0001;
                3'd1, 3'd2, 3'd3:    stop_mask = 4'b0011;
                default:             stop_mask = 4'b1111;
            endcase
        end
    end
endmodule

// File: rtl/cg_req_merge.sv
module cg_req_merge #(
    parameter int N_REQ = 8
) (
    input  logic [N_REQ-1:0] req,
    input  logic             req_en,
    output logic             hit
);
    assign hit = (|req) & req_en;
endmodule

// File: rtl/cg_reqen_reg.sv
module cg_reqen_reg
    import clkgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [N_CLK-1:0] wdata,
    output logic [N_CLK-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '1;
        else if (wr) q <= wdata;
    end
endmodule

// File: rtl/cg_dom_fsm.sv
module cg_dom_fsm
    import clkgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop,
    input  logic hit,
    output logic clk_en,
    output logic held
);
    dom_state_t state_q, state_d;

    // State register on the falling edge: enable moves while clk is low.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_RUN: begin
                if (stop && hit)  state_d = DS_HELD;   // T_HOLD
                else if (stop)    state_d = DS_OFF;    // T_STOP
            end
            DS_OFF: begin
                if (!stop)        state_d = DS_RUN;    // T_WAKE
                else if (hit)     state_d = DS_HELD;   // T_REQ_ON
            end
            DS_HELD: begin
                if (!stop)        state_d = DS_RUN;    // T_RELEASE
                else if (!hit)    state_d = DS_OFF;    // T_REQ_OFF
            end
            default:              state_d = DS_RUN;
        endcase
    end

    always_comb begin
        clk_en = 1'b1;
        held   = 1'b0;
        unique case (state_q)
            DS_RUN:  begin clk_en = 1'b1; held = 1'b0; end
            DS_OFF:  begin clk_en = 1'b0; held = 1'b0; end
            DS_HELD: begin clk_en = 1'b1; held = 1'b1; end
            default: begin clk_en = 1'b1; held = 1'b0; end
        endcase
    end
endmodule

// File: rtl/clk_req_gate_ctrl.sv
module clk_req_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int N_REQ = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sleep,
    input  logic [2:0]             lpm_lvl,
    input  logic [4*N_REQ-1:0]     periph_req,
    input  logic                   reqen_wr,
    input  logic [3:0]             reqen_wdata,
    output logic [3:0]             reqen_q,
    output logic [3:0]             clk_en,
    output logic [3:0]             ovr_hold,
    output logic                   ovr_any
);
    logic [N_CLK-1:0] stop_mask;
    logic [N_CLK-1:0] hit;

    cg_reqen_reg u_reqen (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reqen_wr),
        .wdata (reqen_wdata),
        .q     (reqen_q)
    );

    cg_lpm_decode u_dec (
        .sleep     (sleep),
        .lpm_lvl   (lpm_lvl),
        .stop_mask (stop_mask)
    );

    for (genvar k = 0; k < N_CLK; k++) begin : g_dom
        cg_req_merge #(.N_REQ(N_REQ)) u_merge (
            .req    (periph_req[k*N_REQ +: N_REQ]),
            .req_en (reqen_q[k]),
            .hit    (hit[k])
        );
        cg_dom_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .stop   (stop_mask[k]),
            .hit    (hit[k]),
            .clk_en (clk_en[k]),
            .held   (ovr_hold[k])
        );
    end

    assign ovr_any = |ovr_hold;
endmodule

// File: rtl/cg_checker.sv
module cg_checker #(
    parameter int N_REQ = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sleep,
    input logic [2:0]         lpm_lvl,
    input logic [4*N_REQ-1:0] periph_req,
    input logic [3:0]         reqen_q,
    input logic [3:0]         clk_en,
    input logic [3:0]         ovr_hold
);
    p_awake_all_run_r2: assert property (@(negedge clk) disable iff (!rst_n)
        !sleep |=> (clk_en == 4'hF) && (ovr_hold == 4'h0));

    p_main_req_holds_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (sleep && (|periph_req[N_REQ-1:0]) && reqen_q[0]) |=> (clk_en[0] && ovr_hold[0]));

    p_sub_req_ignored_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (sleep && (lpm_lvl != 3'd0) && !reqen_q[1]) |=> !clk_en[1]);

    p_aux_stops_deep_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (sleep && (lpm_lvl >= 3'd4) && !((|periph_req[2*N_REQ +: N_REQ]) && reqen_q[2]))
        |=> !clk_en[2]);

    p_no_hold_running_r6: assert property (@(negedge clk) disable iff (!rst_n)
        (sleep && (lpm_lvl == 3'd0)) |=> (ovr_hold[3:1] == 3'b000));
endmodule

bind clk_req_gate_ctrl cg_checker #(.N_REQ(N_REQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .lpm_lvl    (lpm_lvl),
    .periph_req (periph_req),
    .reqen_q    (reqen_q),
    .clk_en     (clk_en),
    .ovr_hold   (ovr_hold)
);

// File: tb/clk_req_gate_ctrl_tb.sv
`timescale 1ns/100ps
module clk_req_gate_ctrl_tb;
    localparam int N_REQ = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sleep = 1'b0;
    logic [2:0]         lpm_lvl = '0;
    logic [4*N_REQ-1:0] periph_req = '0;
    logic               reqen_wr = 1'b0;
    logic [3:0]         reqen_wdata = '0;
    logic [3:0]         reqen_q, clk_en, ovr_hold;
    logic               ovr_any;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [3:0] m_reqen = 4'hF;
    logic       pend_wr = 1'b0;
    logic [3:0] pend_data = '0;
    logic [3:0] last_en = 4'hF, last_hold = 4'h0;

    always #2 clk = ~clk;

    clk_req_gate_ctrl #(.N_REQ(N_REQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .lpm_lvl(lpm_lvl),
        .periph_req(periph_req), .reqen_wr(reqen_wr), .reqen_wdata(reqen_wdata),
        .reqen_q(reqen_q), .clk_en(clk_en), .ovr_hold(ovr_hold), .ovr_any(ovr_any)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] stop_of(input logic s, input logic [2:0] l);
        if (!s)          return 4'b0000;
        else if (l == 0) return 4'b0001;
        else if (l <= 3) return 4'b0011;
        else             return 4'b1111;
    endfunction

    task automatic step(input string tag, input logic s, input logic [2:0] l,
                        input logic [4*N_REQ-1:0] r, input logic wr, input logic [3:0] wd);
        logic [3:0] stp, hitv, e_en, e_hold;
        @(posedge clk);
        if (pend_wr) m_reqen = pend_data;
        #0.5;
        // R8: no change across the rising edge
        chk("R8", "clk_en at rise", int'(clk_en), int'(last_en));
        chk("R8", "ovr_hold at rise", int'(ovr_hold), int'(last_hold));
        #0.5;
        sleep = s; lpm_lvl = l; periph_req = r; reqen_wr = wr; reqen_wdata = wd;
        pend_wr = wr; pend_data = wd;
        @(negedge clk);
        #1;
        stp = stop_of(s, l);
        for (int k = 0; k < 4; k++) hitv[k] = (|r[k*N_REQ +: N_REQ]) & m_reqen[k];
        e_en   = ~stp | hitv;
        e_hold = stp & hitv;
        chk(tag, "clk_en", int'(clk_en), int'(e_en));
        chk(tag, "ovr_hold", int'(ovr_hold), int'(e_hold));
        chk("R7", "ovr_any", int'(ovr_any), int'(|e_hold));
        chk("R9", "reqen_q", int'(reqen_q), int'(m_reqen));
        last_en = clk_en; last_hold = ovr_hold;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4*N_REQ-1:0] r;
        #9;
        // R1 reset state
        chk("R1", "clk_en", int'(clk_en), 15);
        chk("R1", "ovr_hold", int'(ovr_hold), 0);
        chk("R1", "ovr_any", int'(ovr_any), 0);
        chk("R1", "reqen_q", int'(reqen_q), 15);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk); #1;
        last_en = clk_en; last_hold = ovr_hold;

        // R2 awake with requests
        step("R2", 0, 3'd4, '1, 0, 0);
        step("R2", 0, 3'd0, 32'h0102_0408, 0, 0);
        // R3 every level, no requests
        for (int l = 0; l < 8; l++) step("R3", 1, 3'(l), '0, 0, 0);
        step("R2", 0, 3'd0, '0, 0, 0);
        // R4 walking single line at deepest level
        for (int i = 0; i < 4*N_REQ; i++) begin
            r = '0; r[i] = 1'b1;
            step("R4", 1, 3'd4, r, 0, 0);
        end
        // R6 requests for domains left running at level 0 and 2
        step("R6", 1, 3'd0, '1, 0, 0);
        step("R6", 1, 3'd2, '1, 0, 0);
        // R9 / R5 clear one enable bit at a time
        for (int k = 0; k < 4; k++) begin
            step("R9", 1, 3'd4, '1, 1, ~(4'b1 << k));
            step("R5", 1, 3'd4, '1, 0, 0);
            step("R5", 1, 3'd1, '1, 0, 0);
        end
        step("R5", 1, 3'd4, '1, 1, 4'h0);
        step("R5", 1, 3'd4, '1, 0, 0);
        step("R9", 1, 3'd4, '1, 1, 4'hF);
        step("R4", 1, 3'd4, '1, 0, 0);
        // Random mix
        for (int n = 0; n < 400; n++) begin
            r = '0;
            for (int k = 0; k < 4; k++)
                if ($urandom_range(0, 1) == 1) r[k*N_REQ + $urandom_range(0, N_REQ-1)] = 1'b1;
            step("R4", 1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), r,
                 1'($urandom_range(0, 5) == 0), 4'($urandom_range(0, 15)));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule